// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block holds the pending interrupt conditions of a 16550-style UART and encodes them into the byte that software reads back when it asks why the interrupt line is high. Five raw event inputs come in from the surrounding UART: a receiver line status error, receive data available, a receive character timeout, transmitter holding register empty, and a modem status change. Each has its own enable bit. An enabled event sets a latch. The interrupt request output is high while any latch is set.

A read of the status register returns one byte. That byte names only the most urgent pending source through a fixed priority code. The read clears only that one latch, so a lower source is reported on the next read. The byte also shows the FIFO mode in its top two bits. When status mirroring is enabled, it also copies the transmitter readiness and receiver occupancy into bits 4 and 5. The returned byte is captured on the first cycle of the read strobe and held for as long as the strobe stays high.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x01 and `irq` is 0.
- R2: Bit 0 of the returned byte is active-low. It is 0 if any enabled source was pending when the read began, and 1 if none was.
- R3: Bits 3..1 carry the code of the highest pending source. From highest to lowest priority the codes are: line status error (`src_ev[0]`) 011, receive data available (`src_ev[1]`) 010, receive timeout (`src_ev[2]`) 110, transmitter empty (`src_ev[3]`) 001, modem change (`src_ev[4]`) 000. Data available and timeout share one level; when both are pending, data available is reported first. With nothing pending, bits 3..1 are 000.
- R4: The clock edge that ends the first cycle of a read clears only the latch of the reported source. Every other pending latch remains and is reported on later reads.
- R5: The byte is sampled before the clear takes effect. If an event for the cleared source arrives in the same cycle as the clear, the event sets the latch again.
- R6: `src_en[i]` gates source i. An event whose enable is 0 is never latched. Driving an enable to 0 drops that source's pending latch at the next edge.
- R7: `irq` is 1 exactly while at least one enabled latch is set. It rises at the same clock edge that latches the event.
- R8: With `mirror_en` = 1, bit 4 equals `tx_ready` and bit 5 equals `rx_nonempty`. With `mirror_en` = 0, both bits are 0.
- R9: Bits 7 and 6 both equal `fifo_mode`.
- R10: While `rd_stb` stays high across several cycles, `rd_data` holds the byte captured on the first cycle, and only one latch is cleared for the whole read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ev | input | 5 | Raw events: [0] line error, [1] data available, [2] timeout, [3] transmitter empty, [4] modem change |
| src_en | input | 5 | Per-source enables, same bit order as `src_ev` |
| fifo_mode | input | 1 | 1 when the FIFOs are in use |
| mirror_en | input | 1 | Enables copying readiness flags into bits 5..4 |
| tx_ready | input | 1 | Transmitter empty, or below its threshold in FIFO mode |
| rx_nonempty | input | 1 | Receiver holds at least one character |
| rd_stb | input | 1 | Status register read strobe, may last several cycles |
| rd_data | output | 8 | Captured interrupt status byte |
| irq | output | 1 | Interrupt request |

## Verification
A latch that is set wrongly or left uncleared shows at `irq` right after the edge where it goes wrong. It also shows in bit 0 and bits 3..1 of the next read, which appear one edge after the strobe rises. A priority or clear-selection error stays hidden until several sources are pending at once. So the bench fills all five latches and drains them read by read, where a lost or doubled clear changes the order of the codes and the read on which 0x01 first comes back. Collisions between a clear and a new event, and reads held over several cycles, are driven on purpose, because a fault there would show only as one extra or one missing read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NSRC   = 5;
  localparam int CODE_W = 3;

  // Source index doubles as priority rank: lower index wins
  localparam int SRC_LINE = 0;
  localparam int SRC_RXAV = 1;
  localparam int SRC_RXTO = 2;
  localparam int SRC_TXE  = 3;
  localparam int SRC_MDM  = 4;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic [1:0] fifo_on;
    logic       rx_mirror;
    logic       tx_mirror;
    code_t      src_code;
    logic       idle;
  } stat_t;

  localparam stat_t STAT_RESET = '{fifo_on: 2'b00, rx_mirror: 1'b0,
                                   tx_mirror: 1'b0, src_code: '0, idle: 1'b1};

  function automatic code_t code_of(input int idx);
    case (idx)
      SRC_LINE: return 3'b011;
      SRC_RXAV: return 3'b010;
      SRC_RXTO: return 3'b110;
      SRC_TXE:  return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] en,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend,
  output logic [N-1:0] pend_nxt
);

  for (genvar g = 0; g < N; g++) begin : g_src
    // a new event outranks the clear; a dropped enable empties the latch
    assign pend_nxt[g] = (pend[g] & en[g] & ~clr[g]) | (ev[g] & en[g]);

    always_ff @(posedge clk) begin
      if (rst) pend[g] <= 1'b0;
      else     pend[g] <= pend_nxt[g];
    end
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  // lowest index has the highest priority
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_irq_rdport.sv
module uart_irq_rdport
  import uart_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_stb,
  input  stat_t live,
  output logic  take,
  output stat_t snap
);

  logic rd_prev;

  assign take = rd_stb & ~rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev <= 1'b0;
      snap    <= STAT_RESET;
    end else begin
      rd_prev <= rd_stb;
      if (take) snap <= live;
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_ev,
  input  logic [NSRC-1:0] src_en,
  input  logic            fifo_mode,
  input  logic            mirror_en,
  input  logic            tx_ready,
  input  logic            rx_nonempty,
  input  logic            rd_stb,
  output logic [7:0]      rd_data,
  output logic            irq
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] pend_nxt;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] clr;
  logic            take;
  code_t           win_code;
  stat_t           live;
  stat_t           snap;
  logic            irq_q;

  uart_irq_latch #(.N(NSRC)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .ev       (src_ev),
    .en       (src_en),
    .clr      (clr),
    .pend     (pend),
    .pend_nxt (pend_nxt)
  );

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req   (pend),
    .grant (grant)
  );

  always_comb begin
    win_code = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) win_code = win_code | code_of(i);
    end
  end

  always_comb begin
    live.fifo_on   = {2{fifo_mode}};
    live.rx_mirror = mirror_en & rx_nonempty;
    live.tx_mirror = mirror_en & tx_ready;
    live.src_code  = win_code;
    live.idle      = ~|pend;
  end

  uart_irq_rdport u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_stb (rd_stb),
    .live   (live),
    .take   (take),
    .snap   (snap)
  );

  // only the source reported by this read is acknowledged
  assign clr = take ? grant : '0;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_nxt;
  end

  assign irq     = irq_q;
  assign rd_data = snap;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            rd_stb,
  input logic            irq,
  input logic            fifo_mode,
  input logic            mirror_en,
  input logic [7:0]      rd_data,
  input logic [NSRC-1:0] src_ev,
  input logic [NSRC-1:0] src_en,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] clr
);

  logic rd_prev_c;
  logic take_c;

  always_ff @(posedge clk) begin
    if (rst) rd_prev_c <= 1'b0;
    else     rd_prev_c <= rd_stb;
  end

  assign take_c = rd_stb & ~rd_prev_c;

  assert_reset_byte_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_data == 8'h01 && !irq));

  assert_idle_bit_R2: assert property (@(posedge clk) disable iff (rst)
    $past(take_c) |-> (rd_data[0] == !$past(irq)));

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(take_c) && !rd_data[0]) |->
      (rd_data[3:1] != 3'b100 && rd_data[3:1] != 3'b101 && rd_data[3:1] != 3'b111));

  assert_code_idle_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(take_c) && rd_data[0]) |-> (rd_data[3:1] == 3'b000));

  assert_clear_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr));

  assert_clear_one_R4: assert property (@(posedge clk) disable iff (rst)
    (take_c && pend != '0) |-> ($countones(clr) == 1));

  assert_clear_only_on_read_R4: assert property (@(posedge clk) disable iff (rst)
    !take_c |-> (clr == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ((clr & src_ev & src_en) != '0) |=>
      ((pend & $past(clr & src_ev & src_en)) == $past(clr & src_ev & src_en)));

  assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (src_en != '1) |=> ((pend & ~$past(src_en)) == '0));

  assert_irq_track_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (pend != '0));

  assert_mirror_off_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(take_c) && !$past(mirror_en)) |-> (rd_data[5:4] == 2'b00));

  assert_mode_bits_R9: assert property (@(posedge clk) disable iff (rst)
    $past(take_c) |-> (rd_data[7:6] == {2{$past(fifo_mode)}}));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_prev_c) |=> $stable(rd_data));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_stb    (rd_stb),
  .irq       (irq),
  .fifo_mode (fifo_mode),
  .mirror_en (mirror_en),
  .rd_data   (rd_data),
  .src_ev    (src_ev),
  .src_en    (src_en),
  .pend      (pend),
  .clr       (clr)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] src_ev;
  logic [4:0] src_en;
  logic       fifo_mode, mirror_en, tx_ready, rx_nonempty, rd_stb;
  logic [7:0] rd_data;
  logic       irq;

  int vectors     = 0;
  int miscompares = 0;
  bit done        = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  logic [4:0] m_pend;

  always #10 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst(rst), .src_ev(src_ev), .src_en(src_en),
    .fifo_mode(fifo_mode), .mirror_en(mirror_en), .tx_ready(tx_ready),
    .rx_nonempty(rx_nonempty), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [2:0] tb_code(input int i);
    logic [2:0] t [5] = '{3'b011, 3'b010, 3'b110, 3'b001, 3'b000};
    return t[i];
  endfunction

  function automatic int top_src();
    logic [4:0] act = m_pend & src_en;
    for (int i = 0; i < 5; i++) if (act[i]) return i;
    return -1;
  endfunction

  function automatic logic [7:0] model_byte();
    int w = top_src();
    logic [2:0] c = (w >= 0) ? tb_code(w) : 3'b000;
    return {{2{fifo_mode}}, mirror_en & rx_nonempty, mirror_en & tx_ready, c, (w < 0)};
  endfunction

  task automatic chk8(input logic [7:0] act, input logic [7:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    src_ev = m;
    m_pend = m_pend | (m & src_en);
    @(negedge clk);
    src_ev = '0;
  endtask

  task automatic set_en(input logic [4:0] m);
    @(negedge clk);
    src_en = m;
    m_pend = m_pend & m;
    @(negedge clk);
  endtask

  // driver: predicts the byte, pushes it, then performs the read
  task automatic do_read(input logic [4:0] ev_same, input int hold, input string tag);
    exp_t e;
    int   w;
    @(negedge clk);
    e.exp = model_byte();
    e.tag = tag;
    sb_q.push_back(e);
    w = top_src();
    rd_stb = 1'b1;
    src_ev = ev_same;
    if (w >= 0) m_pend[w] = 1'b0;
    m_pend = m_pend | (ev_same & src_en);
    @(negedge clk);
    src_ev = '0;
    for (int k = 1; k < hold; k++) begin
      @(negedge clk);
      chk8(rd_data, e.exp, "R10 byte held during long read");
    end
    rd_stb = 1'b0;
  endtask

  // monitor: compares the captured byte after each read edge
  initial begin : monitor
    logic prev = 1'b0;
    logic fire;
    exp_t e;
    forever begin
      @(posedge clk);
      fire = rd_stb && !prev && !rst;
      prev = rd_stb;
      if (fire) begin
        @(negedge clk);
        if (sb_q.size() == 0) begin
          vectors++;
          miscompares++;
          $display("FAIL R2 unexpected read: got %02h expected none", rd_data);
        end else begin
          e = sb_q.pop_front();
          chk8(rd_data, e.exp, e.tag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R1..: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    rst = 1'b1; src_ev = '0; src_en = 5'b11111; fifo_mode = 1'b0; mirror_en = 1'b0;
    tx_ready = 1'b0; rx_nonempty = 1'b0; rd_stb = 1'b0; m_pend = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk8(rd_data, 8'h01, "R1 reset byte");
    chk1(irq, 1'b0, "R1 reset irq");

    // each source on its own (R3 codes, R7 irq, R4 cleared)
    for (int s = 0; s < 5; s++) begin
      pulse(5'(1) << s);
      chk1(irq, 1'b1, "R7 irq after single event");
      do_read('0, 1, "R3 single source code");
      chk1(irq, 1'b0, "R7 irq drops after clear");
      do_read('0, 1, "R4 nothing left after clear");
    end

    // all pending: drained in priority order, one per read
    pulse(5'b11111);
    do_read('0, 1, "R3 order line first");
    chk8(rd_data, 8'h06, "R3 line code 011");
    do_read('0, 1, "R3 order data before timeout");
    chk8(rd_data, 8'h04, "R3 data code 010");
    do_read('0, 1, "R3 order timeout");
    chk8(rd_data, 8'h0C, "R3 timeout code 110");
    do_read('0, 1, "R4 transmitter still pending");
    chk8(rd_data, 8'h02, "R4 transmitter code 001");
    do_read('0, 1, "R4 modem still pending");
    chk8(rd_data, 8'h00, "R2 modem code 000 pending");
    do_read('0, 1, "R2 idle after drain");
    chk1(irq, 1'b0, "R7 irq low after drain");

    // enable gating
    set_en(5'b10111);
    pulse(5'b01000);
    chk1(irq, 1'b0, "R6 disabled event no irq");
    do_read('0, 1, "R6 disabled source not reported");
    set_en(5'b11111);
    chk1(irq, 1'b0, "R6 disabled event was not latched");
    pulse(5'b00001);
    chk1(irq, 1'b1, "R7 irq on line error");
    set_en(5'b11110);
    chk1(irq, 1'b0, "R6 disable drops latch");
    set_en(5'b11111);
    do_read('0, 1, "R6 dropped latch stays gone");

    // mirroring and mode bits
    @(negedge clk);
    fifo_mode = 1'b1; mirror_en = 1'b1; tx_ready = 1'b1; rx_nonempty = 1'b0;
    pulse(5'b10000);
    do_read('0, 1, "R8 R9 tx mirror with modem");
    chk8(rd_data, 8'hD0, "R8 tx mirror byte");
    @(negedge clk);
    tx_ready = 1'b0; rx_nonempty = 1'b1;
    do_read('0, 1, "R8 rx mirror idle");
    chk8(rd_data, 8'hE1, "R8 rx mirror byte");
    @(negedge clk);
    mirror_en = 1'b0; tx_ready = 1'b1;
    do_read('0, 1, "R8 mirror disabled");
    chk8(rd_data, 8'hC1, "R8 mirror off byte");
    @(negedge clk);
    fifo_mode = 1'b0;
    do_read('0, 1, "R9 non-FIFO mode bits");

    // clear colliding with a new event of the same source
    pulse(5'b10000);
    do_read(5'b10000, 1, "R5 modem read with new event");
    chk1(irq, 1'b1, "R5 event re-sets latch");
    do_read('0, 1, "R5 re-set modem reported");
    do_read('0, 1, "R5 idle afterwards");

    // byte sampled before the clear; a new higher event lands after
    pulse(5'b01000);
    do_read(5'b00001, 1, "R5 snapshot predates new event");
    chk8(rd_data, 8'h02, "R5 transmitter reported");
    do_read('0, 1, "R5 line reported next");
    do_read('0, 1, "R5 idle after line");

    // long read clears exactly one source
    pulse(5'b01001);
    do_read('0, 4, "R10 long read first byte");
    chk1(irq, 1'b1, "R10 second source survives long read");
    do_read('0, 1, "R10 transmitter after long read");
    do_read('0, 1, "R10 idle");

    repeat (4) @(negedge clk);
    vectors++;
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL R2 reads missing: got %0d expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule